// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the byte-wide serial port of a telephony codec. On the transmit side it takes an 8-bit companded code in parallel and shifts it out most significant bit first on a data pin with a separate output enable, which a pad turns into a tri-state driver. On the receive side it collects eight serial bits and presents them as a parallel byte with a one-cycle strobe. The block contains no companding arithmetic.

The bit clocks and frame syncs arrive as plain levels and are sampled on a fast system clock, which must run well above the bit rate. The port measures each transmit sync pulse. A pulse that covers a single falling bit-clock edge means short-frame timing. A pulse that covers three or more falling edges means long-frame timing. The chosen timing governs both directions from the next frame on. An active-low slot indicator is low exactly while the transmit driver is enabled. A select input lets the receive path use the transmit bit clock in synchronous systems, or its own bit clock otherwise.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in short-frame timing, `tx_oe` is 0, `tx_dout` is 0, `tslot_n` is 1 and `rx_valid` is 0.
- R2: In short-frame timing, if `fsync_x` is high at a falling edge of `bclk_x`, the next rising edge sets `tx_oe` and drives bit 7 of the code. Each of the seven rising edges that follow drives the next lower bit. The falling edge after the eighth rising edge clears `tx_oe`.
- R3: When an `fsync_x` pulse ends, the port classifies it. A pulse high across three or more falling `bclk_x` edges selects long-frame timing, and any shorter pulse selects short-frame timing. The new timing applies to frames that start after the pulse ends. `fsync_r` never affects the classification.
- R4: In long-frame timing, `tx_oe` is set by whichever comes later: the rise of `fsync_x` or a rising edge of `bclk_x`. That edge drives bit 7, and the next seven rising edges drive bits 6 down to 0.
- R5: In long-frame timing, `tx_oe` is cleared by whichever comes later: the falling `bclk_x` edge after the eighth rising edge, or `fsync_x` going low.
- R6: In short-frame timing, a high `fsync_r` at a falling edge of the receive bit clock arms reception. The next eight falling edges latch bits 7 down to 0. In long-frame timing, the rise of `fsync_r` arms reception, and the next eight falling edges latch the byte. After the eighth bit, `rx_data` holds the byte and `rx_valid` is high for one clock.
- R7: The code on `tx_code` is captured at each rise of `fsync_x` and is transmitted in the slot of the following sync pulse.
- R8: `tslot_n` is low exactly while `tx_oe` is high.
- R9: `tx_oe` stays low through the first `fsync_x` pulse after reset. Transmission begins with the second pulse.
- R10: With `rx_clk_sel` = 1 the receive path is clocked by `bclk_x`. With `rx_clk_sel` = 0 it is clocked by `bclk_r`, and toggling `bclk_x` then delivers no received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every other input |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_x | input | 1 | Transmit bit clock level |
| bclk_r | input | 1 | Receive bit clock level (used when `rx_clk_sel` = 0) |
| fsync_x | input | 1 | Transmit frame sync |
| fsync_r | input | 1 | Receive frame sync |
| rx_clk_sel | input | 1 | 1: receive uses `bclk_x`; 0: receive uses `bclk_r` |
| rx_din | input | 1 | Serial receive data |
| tx_code | input | 8 | Code to send in the next frame |
| tx_dout | output | 1 | Serial transmit data, MSB first |
| tx_oe | output | 1 | Enable for the transmit data driver |
| tslot_n | output | 1 | Low during the transmit slot |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe on a new `rx_data` |

## Verification
The bench builds the block with its defaults: an 8-bit code, a long-frame threshold of three bit clocks and a power-up hold of two sync pulses. The bit clock period is eight system clocks, so every bit-clock edge is a separate sampled event, and enable timing can be checked to the half bit. With a threshold of three, sync widths of one, four and ten bit periods all fall inside a sixteen-period frame. That brings within reach the frames that switch timing, the long slot held open by a late sync fall, and the power-up hold.

// File: rtl/pcm_port_pkg.sv
// Package: shared types of the PCM serial port.
package pcm_port_pkg;
    // Frame timing chosen from the measured transmit sync width.
    typedef enum logic {
        FRM_SHORT = 1'b0,
        FRM_LONG  = 1'b1
    } frame_mode_e;
endpackage

// File: rtl/pcm_edge_det.sv
// Module: pcm_edge_det
// Registers each sampled level once and flags its rising and falling edges.
// Assumes the inputs are already synchronous to clk (bit clocks are slow
// and are produced in the clk domain).
module pcm_edge_det #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] prev
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Hold the previous sample of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/pcm_frame_classifier.sv
// Module: pcm_frame_classifier
// Counts the falling bit-clock edges seen while the transmit sync is high
// and, when the pulse ends, selects long timing if the count reached
// LONG_MIN, short timing otherwise. Starts in short timing.
module pcm_frame_classifier
    import pcm_port_pkg::*;
#(
    parameter int LONG_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_fall,
    input  logic        fs_lvl,
    input  logic        fs_fall,
    output frame_mode_e mode
);
    localparam int HW = $clog2(LONG_MIN + 1);

    logic [HW-1:0] hi_cnt;

    // Measure the pulse and commit the mode at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            mode   <= FRM_SHORT;
        end else if (fs_fall) begin
            mode   <= (hi_cnt >= HW'(LONG_MIN)) ? FRM_LONG : FRM_SHORT;
            hi_cnt <= '0;
        end else if (bclk_fall && fs_lvl && hi_cnt < HW'(LONG_MIN)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R3: timing only changes at the end of a transmit sync pulse.
    a_r3_mode_changes_at_sync_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(fs_fall))
        else $error("R3 mode changed away from a sync end");
endmodule

// File: rtl/pcm_tx_shifter.sv
// Module: pcm_tx_shifter
// Transmit slot: pipelines the code by one sync pulse, picks the slot start
// and end by the current frame timing, shifts MSB first and holds the
// driver off until PWRUP_SYNCS sync pulses have been seen.
module pcm_tx_shifter
    import pcm_port_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int PWRUP_SYNCS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_mode_e       mode,
    input  logic              bclk_lvl,
    input  logic              bclk_prev,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_prev,
    input  logic              fs_rise,
    input  logic [CODE_W-1:0] code_in,
    output logic              dout,
    output logic              oe,
    output logic              slot_n
);
    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam int GATE_W = $clog2(PWRUP_SYNCS + 1);

    logic [CODE_W-1:0] pend_code, send_code, shift_q, load_code;
    logic [CNT_W-1:0]  bit_cnt;
    logic [GATE_W-1:0] seen_q;
    logic active_q, done_q, armed_q, taken_q, oe_q;
    logic start_short, start_long, start, last_fall, finish, gate_next;

    always_comb begin
        start_short = (mode == FRM_SHORT) && armed_q && bclk_rise && !active_q;
        start_long  = (mode == FRM_LONG) && fs_lvl && bclk_lvl
                      && !(fs_prev && bclk_prev) && !taken_q && !active_q;
        start       = start_short || start_long;
        last_fall   = bclk_fall && (bit_cnt == CNT_W'(CODE_W));
        finish      = active_q && (done_q || last_fall)
                      && ((mode == FRM_SHORT) || !fs_lvl);
        load_code   = fs_rise ? pend_code : send_code;
        gate_next   = (seen_q >= GATE_W'(PWRUP_SYNCS))
                      || (fs_rise && (seen_q >= GATE_W'(PWRUP_SYNCS - 1)));
    end

    // Code pipeline: a code taken at one sync rise is sent at the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code <= '0;
            send_code <= '0;
        end else if (fs_rise) begin
            send_code <= pend_code;
            pend_code <= code_in;
        end
    end

    // Count sync pulses since reset, saturating at the power-up hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        seen_q <= '0;
        else if (fs_rise && seen_q < GATE_W'(PWRUP_SYNCS)) seen_q <= seen_q + 1'b1;
    end

    // Short arm on a sampled-high sync; long one-shot guard per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            if (start_short)
                armed_q <= 1'b0;
            else if (bclk_fall && fs_lvl && mode == FRM_SHORT && !active_q)
                armed_q <= 1'b1;
            if (!fs_lvl)        taken_q <= 1'b0;
            else if (start_long) taken_q <= 1'b1;
        end
    end

    // Slot control: load, shift on rising edges, end by the mode's rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            oe_q     <= 1'b0;
            bit_cnt  <= '0;
            shift_q  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            done_q   <= 1'b0;
            bit_cnt  <= CNT_W'(1);
            shift_q  <= load_code;
            oe_q     <= gate_next;
        end else if (finish) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (active_q) begin
            if (bclk_rise && bit_cnt < CNT_W'(CODE_W)) begin
                shift_q <= {shift_q[CODE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (last_fall) done_q <= 1'b1;
        end
    end

    assign oe     = oe_q;
    assign dout   = oe_q & shift_q[CODE_W-1];
    assign slot_n = ~oe_q;

    // R4: the driver only turns on while the bit clock is high.
    a_r4_enable_on_high_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(bclk_lvl))
        else $error("R4 enable without a high bit clock");
    // R2: never more than CODE_W bits in a slot.
    a_r2_bit_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CODE_W))
        else $error("R2 bit count overflow");
    // R5: in long timing the driver stays on while the sync is high.
    a_r5_long_drop_waits_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_q) && $past(mode) == FRM_LONG) |-> !$past(fs_lvl))
        else $error("R5 long slot ended with sync high");
    // R9: silent until the power-up hold has passed.
    a_r9_silent_until_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q < GATE_W'(PWRUP_SYNCS)) |-> !oe_q)
        else $error("R9 driver on before hold passed");
endmodule

// File: rtl/pcm_rx_shifter.sv
// Module: pcm_rx_shifter
// Receive slot: armed by the sync according to the frame timing, latches
// CODE_W bits MSB first on falling bit-clock edges, then strobes the byte.
module pcm_rx_shifter
    import pcm_port_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_mode_e       mode,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  logic              din,
    output logic [CODE_W-1:0] data,
    output logic              valid
);
    localparam int CNT_W = $clog2(CODE_W + 1);

    logic [CNT_W-1:0]  left_q;
    logic [CODE_W-1:0] shift_q;
    logic trig;

    always_comb begin
        trig = (left_q == '0)
               && (((mode == FRM_SHORT) && bclk_fall && fs_lvl)
                   || ((mode == FRM_LONG) && fs_rise));
    end

    // Arm, collect bits, publish the byte with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            shift_q <= '0;
            data    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (left_q != '0) begin
                if (bclk_fall) begin
                    shift_q <= {shift_q[CODE_W-2:0], din};
                    left_q  <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        data  <= {shift_q[CODE_W-2:0], din};
                        valid <= 1'b1;
                    end
                end
            end else if (trig) begin
                left_q <= CNT_W'(CODE_W);
            end
        end
    end

    // R6: the strobe never lasts two cycles.
    a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid)
        else $error("R6 strobe longer than one cycle");
    // R6: bits left never exceed a byte.
    a_r6_left_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CNT_W'(CODE_W))
        else $error("R6 receive counter overflow");
endmodule

// File: rtl/pcm_serial_port.sv
// Module: pcm_serial_port (top)
// Samples bit clocks and syncs, selects the receive bit clock, classifies
// frame timing from the transmit sync and runs both slot engines.
// Assumes clk is several times faster than either bit clock.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int LONG_MIN    = 3,
    parameter int PWRUP_SYNCS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_x,
    input  logic              bclk_r,
    input  logic              fsync_x,
    input  logic              fsync_r,
    input  logic              rx_clk_sel,
    input  logic              rx_din,
    input  logic [CODE_W-1:0] tx_code,
    output logic              tx_dout,
    output logic              tx_oe,
    output logic              tslot_n,
    output logic [CODE_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int NLINES = 4;
    localparam int I_BX = 0, I_FX = 1, I_BR = 2, I_FR = 3;

    logic [NLINES-1:0] lines, rise, fall, prev;
    logic rx_bclk;
    frame_mode_e mode;

    assign rx_bclk = rx_clk_sel ? bclk_x : bclk_r;
    assign lines   = {fsync_r, rx_bclk, fsync_x, bclk_x};

    pcm_edge_det #(.WIDTH(NLINES)) u_edges (
        .clk(clk), .rst_n(rst_n), .sig(lines),
        .rise(rise), .fall(fall), .prev(prev)
    );

    pcm_frame_classifier #(.LONG_MIN(LONG_MIN)) u_class (
        .clk(clk), .rst_n(rst_n), .bclk_fall(fall[I_BX]),
        .fs_lvl(fsync_x), .fs_fall(fall[I_FX]), .mode(mode)
    );

    pcm_tx_shifter #(.CODE_W(CODE_W), .PWRUP_SYNCS(PWRUP_SYNCS)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .bclk_lvl(bclk_x), .bclk_prev(prev[I_BX]),
        .bclk_rise(rise[I_BX]), .bclk_fall(fall[I_BX]),
        .fs_lvl(fsync_x), .fs_prev(prev[I_FX]), .fs_rise(rise[I_FX]),
        .code_in(tx_code), .dout(tx_dout), .oe(tx_oe), .slot_n(tslot_n)
    );

    pcm_rx_shifter #(.CODE_W(CODE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .bclk_fall(fall[I_BR]), .fs_lvl(fsync_r), .fs_rise(rise[I_FR]),
        .din(rx_din), .data(rx_data), .valid(rx_valid)
    );
endmodule

// File: tb/pcm_serial_port_tb.sv
// Directed bench: one task per frame scenario, each checking its own slot.
module pcm_serial_port_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk_x = 1'b0, bclk_r = 1'b0, fsync_x = 1'b0, fsync_r = 1'b0;
    logic rx_clk_sel = 1'b1, rx_din = 1'b0;
    logic [7:0] tx_code = 8'h00;
    logic tx_dout, tx_oe, tslot_n, rx_valid;
    logic [7:0] rx_data;

    int checks = 0, failures = 0;
    int got_cnt = 0;
    logic [7:0] got_byte = 8'h00;
    bit mode_long = 1'b0;
    int syncs_m = 0;
    logic [7:0] pend_m = 8'h00;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    pcm_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_x(bclk_x), .bclk_r(bclk_r),
        .fsync_x(fsync_x), .fsync_r(fsync_r), .rx_clk_sel(rx_clk_sel),
        .rx_din(rx_din), .tx_code(tx_code), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .tslot_n(tslot_n), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // Collect received bytes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            got_cnt  = got_cnt + 1;
            got_byte = rx_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One 16-bit-period frame; expectations come from the bench's own model.
    task automatic run_frame(input string req, input int fxw, input int frw,
                             input bit tog_x, input bit tog_r,
                             input logic [7:0] code, input logic [7:0] rbyte,
                             input bit expect_rx);
        logic [7:0] sent = 8'h00;
        int hs = 0, he = 0, s = 0, rx_s, oe_err = 0, ts_err = 0, dx_err = 0;
        int got0 = got_cnt;
        bit fm_long = mode_long;
        if (fxw > 0) begin
            sent = pend_m; pend_m = code; syncs_m++;
        end
        if (fxw > 0 && tog_x && syncs_m >= 2) begin
            if (!fm_long) begin s = 1; hs = 2; he = 17; end
            else begin s = 0; hs = 0; he = (2 * fxw > 15) ? 2 * fxw : 15; end
        end
        rx_s = fm_long ? 0 : 1;
        tx_code = code;
        for (int k = 0; k < 16; k++) begin
            if (tog_x) bclk_x = 1'b1;
            if (tog_r) bclk_r = 1'b1;
            fsync_x = (k < fxw);
            fsync_r = (k < frw);
            rx_din = (k >= rx_s && k < rx_s + 8) ? rbyte[7 - (k - rx_s)] : k[0];
            for (int half = 0; half < 2; half++) begin
                int h = 2 * k + half;
                bit exp_oe = (h >= hs) && (h < he);
                wait_n(2);
                if (tx_oe !== exp_oe) oe_err++;
                if (tslot_n !== ~tx_oe) ts_err++;
                if (exp_oe && (k - s) < 8 && tx_dout !== sent[7 - (k - s)]) dx_err++;
                wait_n(2);
                if (half == 0) begin bclk_x = 1'b0; bclk_r = 1'b0; end
            end
        end
        wait_n(2);
        check(oe_err == 0, req, "enable window mismatches", oe_err, 0);
        check(ts_err == 0, "R8", "slot indicator mismatches", ts_err, 0);
        check(dx_err == 0, req, "data bit mismatches", dx_err, 0);
        if (expect_rx)
            check(got_cnt == got0 + 1 && got_byte == rbyte, "R6", "received byte",
                  got_byte, rbyte);
        else
            check(got_cnt == got0, "R10", "unexpected byte count", got_cnt - got0, 0);
        if (fxw > 0) mode_long = (fxw >= 3);
    endtask

    task automatic test_reset();
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        check(tx_oe === 1'b0 && tx_dout === 1'b0, "R1", "tx idle", tx_oe, 0);
        check(tslot_n === 1'b1, "R1", "slot indicator idle", tslot_n, 1);
        check(rx_valid === 1'b0, "R1", "strobe idle", rx_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_reset();
        // R9: first pulse sends nothing; R6 short receive.
        run_frame("R9", 1, 1, 1, 0, 8'hA5, 8'h3C, 1);
        // R2 and R7: second pulse sends the code from the first, short timing.
        run_frame("R2", 1, 1, 1, 0, 8'h5A, 8'hC3, 1);
        // R3: first long pulse still timed short.
        run_frame("R3", 4, 4, 1, 0, 8'h96, 8'h81, 1);
        // R4: long timing now active, sends previous code (R7).
        run_frame("R4", 4, 4, 1, 0, 8'h0F, 8'h7E, 1);
        // R5: sync held past the eighth bit keeps the driver on.
        run_frame("R5", 10, 10, 1, 0, 8'hF0, 8'h18, 1);
        // R3: short pulse while long still uses long timing.
        run_frame("R3", 1, 1, 1, 0, 8'hC9, 8'hE7, 1);
        // R2: short timing restored.
        run_frame("R2", 1, 1, 1, 0, 8'h12, 8'h42, 1);
        // R10: receive on its own clock.
        rx_clk_sel = 1'b0;
        run_frame("R10", 0, 1, 0, 1, 8'h00, 8'hB4, 1);
        // R10: transmit clock ignored by the receive path.
        run_frame("R10", 0, 1, 1, 0, 8'h00, 8'h6D, 0);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule